// File: doc/BRIEF.md
# Banked GPIO Interrupt Controller

A register-mapped general-purpose I/O block organised as banks of up to 32 pins each. Software configures every pin as an input or an output, optionally in open-drain style, and reads back either the written output value or the synchronized pad level. Every pin can also be set up as an interrupt source with one of five trigger types, selected by three independent per-pin configuration bits.

Each bank latches detected events in sticky status bits that software clears by writing ones. A per-bank enable mask gates which status bits contribute to the single interrupt output, which is the OR of every enabled pending bit across all banks. Banks may implement fewer than 32 pins; the missing bits are inert.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: Word address `{bank, idx}` with `idx = addr[2:0]` selects, per bank, idx 0 open-drain enable, 1 data, 2 direction, 3 trigger polarity, 4 any-edge, 5 enable mask, 6 level select, 7 status; bank b starts at word b*8. Configuration registers read back what was written. Addresses of nonexistent banks read zero.
- R2: After reset every implemented pin is an input (direction bits 1), mask, status, data, open-drain and trigger registers are 0, `irq` is low and no pad is driven.
- R3: A direction bit of 0 makes the pin an output that drives the data bit with output-enable on; a direction bit of 1 turns output-enable off. Reading the data register returns the synchronized pad level for input pins and the written value for output pins; pad inputs pass two flops.
- R4: With open-drain enabled on an output pin, data 0 drives low with output-enable on and data 1 releases the pad (output-enable off, `pad_out` 0).
- R5: Level select 1: polarity 1 sets status while the pad is high, polarity 0 sets it while the pad is low.
- R6: Level select 0 and any-edge 0: polarity 1 sets status on a rising edge only, polarity 0 on a falling edge only.
- R7: Level select 0 and any-edge 1: both edges set status regardless of polarity.
- R8: Writing 1 to a status bit clears it, writing 0 leaves it; a clear wins over an event in the same cycle, so a still-active level sets the bit again one cycle later.
- R9: Status bits latch while masked; `irq` is high exactly when some bank has a status bit with its mask bit set.
- R10: Per-bank width parameter: bits at or above a bank's width read zero, never set status and never drive a pad.

Top module port order below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address {bank, register index} |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr` (combinational) |
| pad_in | input | NUM_BANKS*32 | Pad input levels |
| pad_out | output | NUM_BANKS*32 | Pad output values |
| pad_oe | output | NUM_BANKS*32 | Pad output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench targets the trigger decode: a rising-edge pin must ignore falling edges and the reverse, so a design that swapped the edge sense or ignored the polarity bit in any-edge mode shows a wrong status bit. It clears a level-triggered bit while the level is held and checks the bit is zero right after the write and set one cycle later, which catches a design where set beats clear or where the bit never re-arms. It raises an event while masked and only then unmasks, catching a design that gates latching with the mask, and uses a second, 20-pin bank to show that upper bits cannot be written, latched or driven.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd20, 6'd32},
  localparam int BANK_AW = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W = BANK_AW + 3,
  localparam int PINS = NUM_BANKS * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic [PINS-1:0]   pad_in,
  output logic [PINS-1:0]   pad_out,
  output logic [PINS-1:0]   pad_oe,
  output logic              irq
);

  logic [31:0]          rd_bank [NUM_BANKS];
  logic [NUM_BANKS-1:0] pend;
  logic [PINS-1:0]      stat_all, mask_all, dir_all;
  logic [BANK_AW-1:0]   bsel;
  logic [2:0]           ridx;

  assign bsel = addr[ADDR_W-1:3];
  assign ridx = addr[2:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int W = int'(BANK_WIDTHS[b*6 +: 6]);
    localparam logic [31:0] VM = (W >= 32) ? 32'hFFFF_FFFF : ((32'd1 << W) - 32'd1);

    logic [31:0] oden, dout, dir, pol, anye, msk, lvl, stat;
    logic [31:0] s1, s2, s3, evt, wd, clr;
    logic        sel;

    assign sel = wr_en && (bsel == BANK_AW'(b));
    assign wd  = wr_data & VM;
    assign clr = (sel && ridx == 3'd7) ? wd : 32'd0;

    assign evt = VM & ( (lvl & ((pol & s2) | (~pol & ~s2)))
                      | (~lvl &  anye & (s2 ^ s3))
                      | (~lvl & ~anye &  pol &  s2 & ~s3)
                      | (~lvl & ~anye & ~pol & ~s2 &  s3));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        oden <= '0; dout <= '0; dir <= VM; pol <= '0;
        anye <= '0; msk <= '0; lvl <= '0; stat <= '0;
        s1 <= '0; s2 <= '0; s3 <= '0;
      end else begin
        s1 <= pad_in[b*32 +: 32] & VM;
        s2 <= s1;
        s3 <= s2;
        if (sel) begin
          case (ridx)
            3'd0: oden <= wd;
            3'd1: dout <= wd;
            3'd2: dir  <= wd;
            3'd3: pol  <= wd;
            3'd4: anye <= wd;
            3'd5: msk  <= wd;
            3'd6: lvl  <= wd;
            default: ;
          endcase
        end
        stat <= (stat | evt) & ~clr;
      end
    end

    always_comb begin
      case (ridx)
        3'd0: rd_bank[b] = oden;
        3'd1: rd_bank[b] = (dir & s2) | (~dir & dout);
        3'd2: rd_bank[b] = dir;
        3'd3: rd_bank[b] = pol;
        3'd4: rd_bank[b] = anye;
        3'd5: rd_bank[b] = msk;
        3'd6: rd_bank[b] = lvl;
        default: rd_bank[b] = stat;
      endcase
    end

    assign pad_oe[b*32 +: 32]   = VM & ~dir & (~oden | ~dout);
    assign pad_out[b*32 +: 32]  = VM & ~dir & ~oden & dout;
    assign stat_all[b*32 +: 32] = stat;
    assign mask_all[b*32 +: 32] = msk;
    assign dir_all[b*32 +: 32]  = dir;
    assign pend[b] = |(stat & msk);
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NUM_BANKS; i++)
      if (bsel == BANK_AW'(i)) rd_data = rd_bank[i];
  end

  assign irq = |pend;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk #(
  parameter int NUM_BANKS = 2,
  parameter logic [NUM_BANKS*6-1:0] BANK_WIDTHS = {6'd20, 6'd32},
  parameter int ADDR_W = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [ADDR_W-1:0]     addr,
  input logic [31:0]           wr_data,
  input logic                  irq,
  input logic [NUM_BANKS*32-1:0] pad_oe,
  input logic [NUM_BANKS*32-1:0] stat_all,
  input logic [NUM_BANKS*32-1:0] mask_all,
  input logic [NUM_BANKS*32-1:0] dir_all
);

  function automatic logic [NUM_BANKS*32-1:0] valid_bits();
    logic [NUM_BANKS*32-1:0] v = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      for (int i = 0; i < 32; i++)
        if (i < int'(BANK_WIDTHS[b*6 +: 6])) v[b*32+i] = 1'b1;
    return v;
  endfunction

  localparam logic [NUM_BANKS*32-1:0] VALID = valid_bits();

  AST_STAT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(7) && wr_data[0]) |=> !stat_all[0]); // R8

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr[2:0] == 3'd7) |=> ((stat_all & $past(stat_all)) == $past(stat_all))); // R9

  AST_NO_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_all == '0) |-> !irq); // R9

  AST_UNIMPL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat_all | pad_oe) & ~VALID) == '0); // R10

  AST_INPUT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_oe & dir_all) == '0); // R3

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_BANKS(NUM_BANKS), .BANK_WIDTHS(BANK_WIDTHS), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .irq(irq), .pad_oe(pad_oe), .stat_all(stat_all), .mask_all(mask_all),
  .dir_all(dir_all)
);

// File: tb/tb_gpio_irq_ctrl.sv
module tb_gpio_irq_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [3:0]  addr = 0;
  logic        wr_en = 0;
  logic [31:0] wr_data = 0;
  logic [31:0] rd_data;
  logic [63:0] pad_in = 0;
  logic [63:0] pad_out, pad_oe;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_irq_ctrl dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .pad_in(pad_in), .pad_out(pad_out),
    .pad_oe(pad_oe), .irq(irq));

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int bank, int idx, logic [31:0] d);
    @(negedge clk);
    addr = 4'(bank*8 + idx); wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int bank, int idx, output logic [31:0] d);
    addr = 4'(bank*8 + idx);
    #1 d = rd_data;
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, 2, d); chk("R2 dir bank0", d, 32'hFFFF_FFFF);
    rd(1, 2, d); chk("R10 dir bank1", d, 32'h000F_FFFF);
    rd(0, 5, d); chk("R2 mask", d, 0);
    rd(1, 7, d); chk("R2 status", d, 0);
    chk("R2 irq", irq, 0);
    chk("R2 pad_oe", pad_oe, 0);
  endtask

  task automatic t_regmap;
    logic [31:0] d;
    wr(0, 6, 32'h5A5A_0000); rd(0, 6, d); chk("R1 level readback", d, 32'h5A5A_0000);
    wr(0, 4, 32'h0000_C3C3); rd(0, 4, d); chk("R1 anyedge readback", d, 32'h0000_C3C3);
    rd(0, 6, d); chk("R1 level kept", d, 32'h5A5A_0000);
    wr(1, 3, 32'hFFFF_FFFF); rd(1, 3, d); chk("R10 polarity bank1 width", d, 32'h000F_FFFF);
    wr(0, 6, 0); wr(0, 4, 0); wr(1, 3, 0);
    wr(0, 7, 32'hFFFF_FFFF); wr(1, 7, 32'hFFFF_FFFF);
  endtask

  task automatic t_output;
    logic [31:0] d;
    wr(0, 2, 32'hFFFF_0000); wr(0, 1, 32'h1234_ABCD);
    pad_in[31:16] = 16'h5555;
    cyc(3);
    chk("R3 pad_out", pad_out[31:0], 32'h0000_ABCD);
    chk("R3 pad_oe", pad_oe[31:0], 32'h0000_FFFF);
    rd(0, 1, d); chk("R3 data read mix", d, 32'h5555_ABCD);
    wr(0, 0, 32'h0000_000F); wr(0, 1, 32'h0000_000D);
    chk("R4 od oe", pad_oe[3:0], 4'h2);
    chk("R4 od out", pad_out[3:0], 4'h0);
    wr(0, 0, 0); wr(0, 2, 32'hFFFF_FFFF);
    pad_in[31:16] = 0;
    cyc(4);
    wr(0, 7, 32'hFFFF_FFFF);
  endtask

  task automatic t_level;
    logic [31:0] d;
    wr(0, 3, 32'h10); wr(0, 6, 32'h10); wr(0, 7, 32'hFFFF_FFFF);
    rd(0, 7, d); chk("R5 high idle", d, 0);
    pad_in[4] = 1; cyc(4);
    rd(0, 7, d); chk("R5 level high set", d, 32'h10);
    wr(0, 5, 32'h10);
    chk("R9 irq unmasked", irq, 1);
    wr(0, 7, 32'h10);
    rd(0, 7, d); chk("R8 cleared", d, 0);
    cyc(1);
    rd(0, 7, d); chk("R8 level re-set", d, 32'h10);
    pad_in[4] = 0; cyc(4);
    wr(0, 7, 32'h10); cyc(2);
    rd(0, 7, d); chk("R8 stays clear", d, 0);
    chk("R9 irq low", irq, 0);
    wr(0, 3, 0); cyc(1);
    rd(0, 7, d); chk("R5 level low set", d, 32'h10);
    wr(0, 6, 0); wr(0, 5, 0); wr(0, 7, 32'hFFFF_FFFF);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(0, 3, 32'h100); wr(0, 7, 32'hFFFF_FFFF);
    pad_in[8] = 1; cyc(4);
    rd(0, 7, d); chk("R6 rising set", d, 32'h100);
    wr(0, 7, 32'h100);
    pad_in[8] = 0; cyc(4);
    rd(0, 7, d); chk("R6 rising ignores fall", d, 0);
    pad_in[9] = 1; cyc(4);
    rd(0, 7, d); chk("R6 falling ignores rise", d, 0);
    pad_in[9] = 0; cyc(4);
    rd(0, 7, d); chk("R6 falling set", d, 32'h200);
    wr(0, 7, 32'hFFFF_FFFF);
    wr(0, 4, 32'h1000); wr(0, 3, 32'h1100);
    pad_in[12] = 1; cyc(4);
    rd(0, 7, d); chk("R7 both rise", d, 32'h1000);
    wr(0, 7, 32'h0);
    rd(0, 7, d); chk("R8 zero write no effect", d, 32'h1000);
    wr(0, 7, 32'h1);
    rd(0, 7, d); chk("R8 other bit no effect", d, 32'h1000);
    wr(0, 7, 32'h1000);
    pad_in[12] = 0; cyc(4);
    rd(0, 7, d); chk("R7 both fall", d, 32'h1000);
    wr(0, 4, 0); wr(0, 3, 0); wr(0, 7, 32'hFFFF_FFFF);
  endtask

  task automatic t_banks;
    logic [31:0] d;
    wr(1, 3, 32'h8); wr(1, 7, 32'hFFFF_FFFF);
    pad_in[35] = 1; cyc(4);
    rd(1, 7, d); chk("R9 latched while masked", d, 32'h8);
    chk("R9 irq masked", irq, 0);
    wr(1, 5, 32'h8);
    chk("R9 irq bank1", irq, 1);
    wr(1, 7, 32'h8);
    chk("R9 irq after clear", irq, 0);
    wr(1, 4, 32'hFFFF_FFFF);
    pad_in[63:52] = 12'hFFF; cyc(4);
    pad_in[63:52] = 12'h000; cyc(4);
    rd(1, 7, d); chk("R10 no status above width", d, 0);
    wr(1, 2, 0);
    chk("R10 oe bank1", pad_oe[63:32], 32'h000F_FFFF);
    wr(1, 2, 32'hFFFF_FFFF);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    t_reset;
    t_regmap;
    t_output;
    t_level;
    t_edges;
    t_banks;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule